// File: doc/BRIEF.md
# Transmit Clock Supervisor and Line Driver Enable

This block watches the transmit clocks of a four-channel line-interface transmit path and decides, cycle by cycle, whether each channel's differential line driver may be enabled. Everything runs on a free-running master clock. Each transmit clock is brought into that domain through a two-flop synchronizer. A per-channel counter measures how long the synchronized level has stayed unchanged. When it exceeds the stuck limit (70 master-clock cycles by default), the channel's clock is reported as lost.

A rising loss condition sets a sticky per-channel interrupt flag. Software clears a flag by pulsing the matching clear bit. The interrupt output is the OR of the flags whose mask bits are low.

The driver enable merges six conditions in a fixed priority: master clock invalid, global hold, per-channel disable, power-down, transmit-clock loss, and reset. Clock loss is ignored while a channel is in remote loopback or sends an internal pattern timed by the master clock. Enables are registered in the master-clock domain and come out of any reset as zero.

Top module: `txsup_top`

## Requirements
- R1: While `rst` or `sw_rst` is high at a rising edge, the next outputs are `drv_en`=0, `clk_lost`=0, `irq_flag`=0 and `irq`=0.
- R2: If the level on `tclk_in[i]` toggles between edges and then stays put, `clk_lost[i]` is 0 after the 73rd following rising edge and 1 after the 74th (two synchronizer stages, one edge stage, then more than 70 stable cycles).
- R3: A transmit clock that keeps toggling every few master cycles never sets `clk_lost`.
- R4: After a lost clock toggles again, `clk_lost[i]` is still 1 after the 2nd following rising edge and 0 after the 3rd.
- R5: `irq_flag[i]` becomes 1 one edge after `clk_lost[i]` rises, and stays 1 until an edge where `irq_clr[i]` is 1; a new rise wins over a clear in the same cycle. A continuing loss does not set the flag again.
- R6: `irq` is the combinational OR over channels of `irq_flag[i]` AND NOT `irq_mask[i]` (mask bit 1 = masked).
- R7: `glb_hold`=1 at an edge makes every `drv_en` bit 0 after that edge.
- R8: `ch_hiz[i]`=1 disables only channel i.
- R9: `mclk_ok`=0 at an edge makes every `drv_en` bit 0 after that edge.
- R10: `clk_lost[i]`=1 disables channel i unless `ch_rloop[i]` or `ch_intpat[i]` is 1.
- R11: `ch_pwrdn[i]`=1 disables only channel i.
- R12: `drv_en` is registered: a change of any disabling input shows one rising edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running master clock |
| rst | input | 1 | Synchronous active-high reset (pin or power-on) |
| sw_rst | input | 1 | Synchronous active-high software reset |
| mclk_ok | input | 1 | Master clock is valid |
| glb_hold | input | 1 | Global hold-off, disables all drivers |
| tclk_in | input | NUM_CH | Raw transmit clocks, asynchronous to `clk` |
| ch_hiz | input | NUM_CH | Per-channel driver disable bits |
| ch_pwrdn | input | NUM_CH | Per-channel transmit path power-down |
| ch_rloop | input | NUM_CH | Per-channel remote loopback mode |
| ch_intpat | input | NUM_CH | Per-channel internal pattern timed by master clock |
| irq_mask | input | NUM_CH | Interrupt mask, 1 = masked |
| irq_clr | input | NUM_CH | Write-one-to-clear pulses for the flags |
| drv_en | output | NUM_CH | Line driver enable per channel |
| clk_lost | output | NUM_CH | Transmit clock missing status |
| irq_flag | output | NUM_CH | Sticky clock-loss interrupt flags |
| irq | output | 1 | Interrupt, OR of unmasked flags |

## Verification
A stuck-level counter that is off by even one state moves the `clk_lost` rise away from the 74th edge after the last toggle. The directed loss test samples both neighbours of that edge, so the fault shows within the same test. A counter or flag register that does not clear appears at once, as `clk_lost` or `irq_flag` staying high on the edge where the bench expects it low. A wrong priority or a missing exemption in the enable logic shows one edge after the offending control changes, as a `drv_en` pattern that differs from the expected per-channel mask.

// File: rtl/txsup_pkg.sv
package txsup_pkg;

    localparam int NUM_CH      = 4;
    localparam int STUCK_LIMIT = 70;

    // Reason a driver is held off, highest priority first
    typedef enum logic [2:0] {
        OFF_NONE    = 3'd0,
        OFF_MCLK    = 3'd1,
        OFF_GLOBAL  = 3'd2,
        OFF_CHAN    = 3'd3,
        OFF_PWRDN   = 3'd4,
        OFF_CLKLOSS = 3'd5
    } off_cause_e;

    typedef struct packed {
        logic hiz;
        logic pwrdn;
        logic rloop;
        logic intpat;
    } ch_ctrl_t;

    function automatic off_cause_e pick_cause(
        input logic     mclk_ok,
        input logic     glb_hold,
        input ch_ctrl_t c,
        input logic     lost
    );
        off_cause_e r;
        if (!mclk_ok)                            r = OFF_MCLK;
        else if (glb_hold)                       r = OFF_GLOBAL;
        else if (c.hiz)                          r = OFF_CHAN;
        else if (c.pwrdn)                        r = OFF_PWRDN;
        else if (lost && !(c.rloop || c.intpat)) r = OFF_CLKLOSS;
        else                                     r = OFF_NONE;
        return r;
    endfunction

endpackage

// File: rtl/txsup_clkwatch.sv
module txsup_clkwatch #(
    parameter int STUCK_LIMIT = txsup_pkg::STUCK_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic tclk_async,
    output logic lost
);
    localparam int CNT_W = $clog2(STUCK_LIMIT + 2);

    logic             s1, s2, s3;
    logic [CNT_W-1:0] cnt;
    logic             edge_seen;

    assign edge_seen = s2 ^ s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            s3  <= 1'b0;
            cnt <= '0;
        end else begin
            s1 <= tclk_async;
            s2 <= s1;
            s3 <= s2;
            if (edge_seen)
                cnt <= '0;
            else if (cnt <= CNT_W'(STUCK_LIMIT))
                cnt <= cnt + 1'b1;
        end
    end

    assign lost = (cnt > CNT_W'(STUCK_LIMIT));

    // R2
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(STUCK_LIMIT + 1));

    // R2
    lost_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(STUCK_LIMIT) && !edge_seen) |=> lost);

    // R4
    lost_clear_chk: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> !lost);

endmodule

// File: rtl/txsup_irqlog.sv
module txsup_irqlog #(
    parameter int NUM_CH = txsup_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] lost,
    input  logic [NUM_CH-1:0] mask,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flag,
    output logic              irq
);
    logic [NUM_CH-1:0] lost_q;
    logic [NUM_CH-1:0] lost_rise;

    assign lost_rise = lost & ~lost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= '0;
            flag   <= '0;
        end else begin
            lost_q <= lost;
            flag   <= (flag & ~clr) | lost_rise;
        end
    end

    assign irq = |(flag & ~mask);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R5
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            (lost[i] && !lost_q[i]) |=> flag[i]);
        // R5
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !clr[i]) |=> flag[i]);
    end

endmodule

// File: rtl/txsup_drvgate.sv
module txsup_drvgate
    import txsup_pkg::*;
#(
    parameter int NUM_CH = txsup_pkg::NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mclk_ok,
    input  logic                    glb_hold,
    input  ch_ctrl_t [NUM_CH-1:0]   ctrl,
    input  logic [NUM_CH-1:0]       lost,
    output logic [NUM_CH-1:0]       drv_en
);
    logic [NUM_CH-1:0] en_next;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        off_cause_e cause;
        always_comb cause = pick_cause(mclk_ok, glb_hold, ctrl[i], lost[i]);
        assign en_next[i] = (cause == OFF_NONE);

        // R10
        loss_off_chk: assert property (@(posedge clk) disable iff (rst)
            (lost[i] && !ctrl[i].rloop && !ctrl[i].intpat) |=> !drv_en[i]);
        // R11
        pwrdn_off_chk: assert property (@(posedge clk) disable iff (rst)
            ctrl[i].pwrdn |=> !drv_en[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) drv_en <= '0;
        else     drv_en <= en_next;
    end

    // R9
    mclk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mclk_ok |=> (drv_en == '0));

    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        glb_hold |=> (drv_en == '0));

endmodule

// File: rtl/txsup_top.sv
module txsup_top
    import txsup_pkg::*;
#(
    parameter int NUM_CH      = txsup_pkg::NUM_CH,
    parameter int STUCK_LIMIT = txsup_pkg::STUCK_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              mclk_ok,
    input  logic              glb_hold,
    input  logic [NUM_CH-1:0] tclk_in,
    input  logic [NUM_CH-1:0] ch_hiz,
    input  logic [NUM_CH-1:0] ch_pwrdn,
    input  logic [NUM_CH-1:0] ch_rloop,
    input  logic [NUM_CH-1:0] ch_intpat,
    input  logic [NUM_CH-1:0] irq_mask,
    input  logic [NUM_CH-1:0] irq_clr,
    output logic [NUM_CH-1:0] drv_en,
    output logic [NUM_CH-1:0] clk_lost,
    output logic [NUM_CH-1:0] irq_flag,
    output logic              irq
);
    logic                  rst_all;
    ch_ctrl_t [NUM_CH-1:0] ctrl;

    assign rst_all = rst | sw_rst;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ctrl[i] = '{hiz: ch_hiz[i], pwrdn: ch_pwrdn[i],
                           rloop: ch_rloop[i], intpat: ch_intpat[i]};

        txsup_clkwatch #(.STUCK_LIMIT(STUCK_LIMIT)) u_watch (
            .clk        (clk),
            .rst        (rst_all),
            .tclk_async (tclk_in[i]),
            .lost       (clk_lost[i])
        );
    end

    txsup_irqlog #(.NUM_CH(NUM_CH)) u_irq (
        .clk  (clk),
        .rst  (rst_all),
        .lost (clk_lost),
        .mask (irq_mask),
        .clr  (irq_clr),
        .flag (irq_flag),
        .irq  (irq)
    );

    txsup_drvgate #(.NUM_CH(NUM_CH)) u_gate (
        .clk      (clk),
        .rst      (rst_all),
        .mclk_ok  (mclk_ok),
        .glb_hold (glb_hold),
        .ctrl     (ctrl),
        .lost     (clk_lost),
        .drv_en   (drv_en)
    );

    // R1
    reset_off_chk: assert property (@(posedge clk)
        rst_all |=> (drv_en == '0 && clk_lost == '0 && irq_flag == '0 && !irq));

endmodule

// File: tb/txsup_top_tb.sv
module txsup_top_tb;
    localparam int CLK_P = 10;
    localparam int N     = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1, sw_rst = 1'b0, mclk_ok = 1'b1, glb_hold = 1'b0;
    logic [N-1:0] ch_hiz = '0, ch_pwrdn = '0, ch_rloop = '0, ch_intpat = '0;
    logic [N-1:0] irq_mask = '0, irq_clr = '0;
    logic [N-1:0] run = '1, man = '0;
    logic         osc = 1'b0;
    logic [1:0]   div = '0;
    logic [N-1:0] tclk_in;
    logic [N-1:0] drv_en, clk_lost, irq_flag;
    logic         irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    // Free-running transmit clock source, toggles every 3 master cycles
    always @(posedge clk) begin
        if (div == 2'd2) begin div <= '0; osc <= ~osc; end
        else div <= div + 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign tclk_in[i] = run[i] ? osc : man[i];
    end

    txsup_top u_dut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .mclk_ok(mclk_ok),
        .glb_hold(glb_hold), .tclk_in(tclk_in), .ch_hiz(ch_hiz),
        .ch_pwrdn(ch_pwrdn), .ch_rloop(ch_rloop), .ch_intpat(ch_intpat),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .drv_en(drv_en),
        .clk_lost(clk_lost), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        tick(2);
        check("R1 drv_en in reset", 32'(drv_en), 32'h0);
        check("R1 clk_lost in reset", 32'(clk_lost), 32'h0);
        check("R1 irq in reset", {irq_flag, irq}, 32'h0);
        rst = 1'b0;
        tick(1);
        check("R12 drv_en one edge after reset", 32'(drv_en), 32'hF);
    endtask

    task automatic t_running;
        tick(200);
        check("R3 no loss while toggling", 32'(clk_lost), 32'h0);
        check("R3 drivers on", 32'(drv_en), 32'hF);
    endtask

    task automatic t_loss;
        run[1] = 1'b0; man[1] = 1'b0;
        tick(5);
        man[1] = 1'b1;
        tick(73);
        check("R2 not lost at 73", 32'(clk_lost), 32'h0);
        tick(1);
        check("R2 lost at 74", 32'(clk_lost), 32'h2);
        check("R12 drv_en not yet off", 32'(drv_en), 32'hF);
        check("R5 flag not yet set", 32'(irq_flag), 32'h0);
        tick(1);
        check("R10 lost channel disabled", 32'(drv_en), 32'hD);
        check("R5 flag set", 32'(irq_flag), 32'h2);
        check("R6 irq raised", 32'(irq), 32'h1);
    endtask

    task automatic t_mask_clear;
        irq_mask = 4'b0010; #1;
        check("R6 masked irq low", 32'(irq), 32'h0);
        irq_mask = 4'b1101; #1;
        check("R6 other masks no effect", 32'(irq), 32'h1);
        irq_mask = '0;
        tick(3);
        check("R5 flag sticky", 32'(irq_flag), 32'h2);
        irq_clr = 4'b0010;
        tick(1);
        irq_clr = '0;
        check("R5 flag cleared", 32'(irq_flag), 32'h0);
        check("R6 irq low after clear", 32'(irq), 32'h0);
        tick(3);
        check("R5 continuing loss no re-set", 32'(irq_flag), 32'h0);
        check("R5 loss still reported", 32'(clk_lost), 32'h2);
    endtask

    task automatic t_exempt;
        ch_rloop[1] = 1'b1;
        tick(1);
        check("R10 loopback exempt", 32'(drv_en), 32'hF);
        ch_rloop[1] = 1'b0; ch_intpat[1] = 1'b1;
        tick(1);
        check("R10 internal pattern exempt", 32'(drv_en), 32'hF);
        ch_intpat[1] = 1'b0;
        tick(1);
        check("R10 exemption removed", 32'(drv_en), 32'hD);
    endtask

    task automatic t_recover;
        man[1] = 1'b0;
        tick(2);
        check("R4 still lost after 2", 32'(clk_lost), 32'h2);
        tick(1);
        check("R4 cleared after 3", 32'(clk_lost), 32'h0);
        tick(1);
        check("R10 driver back on", 32'(drv_en), 32'hF);
        run[1] = 1'b1;
        tick(10);
    endtask

    task automatic t_controls;
        glb_hold = 1'b1;
        tick(1);
        check("R7 global hold", 32'(drv_en), 32'h0);
        glb_hold = 1'b0;
        tick(1);
        check("R12 hold release", 32'(drv_en), 32'hF);
        ch_hiz = 4'b0100;
        tick(1);
        check("R8 channel disable", 32'(drv_en), 32'hB);
        ch_hiz = '0; ch_pwrdn = 4'b1000;
        tick(1);
        check("R11 power-down", 32'(drv_en), 32'h7);
        ch_pwrdn = '0; mclk_ok = 1'b0;
        tick(1);
        check("R9 master clock loss", 32'(drv_en), 32'h0);
        mclk_ok = 1'b1;
        tick(1);
        check("R9 master clock back", 32'(drv_en), 32'hF);
    endtask

    task automatic t_swreset;
        sw_rst = 1'b1;
        tick(1);
        check("R1 software reset drivers off", 32'(drv_en), 32'h0);
        check("R1 software reset status", {clk_lost, irq_flag, irq}, 32'h0);
        sw_rst = 1'b0;
        tick(1);
        check("R1 after software reset", 32'(drv_en), 32'hF);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_running();
        t_loss();
        t_mask_clear();
        t_exempt();
        t_recover();
        t_controls();
        t_swreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule